// File: doc/BRIEF.md
# Chroma Mute and Dropout Selector

This block sits at the output end of a video noise-reduction path and decides, sample by sample, what reaches the luma and chroma outputs. Each accepted sample carries the current luma/chroma pair and the pair read back from the external delay memory. The block picks the current or the delayed value for each path, and then forces the chroma to the mid-code level when any active mute source asks for it.

There are three mute sources: an overlay blanking strobe, a vertical blanking strobe and a monochrome (colour-kill) strobe. Software can disable the first two. The overlay strobe also has a programmable alignment delay that is counted in samples. A dropout strobe swaps in the delayed value for luma and for chroma, each under its own enable bit. This only happens while the line-based NR mode is selected, because in field or frame mode the delayed signal holds no valid sync content. All four strobes are asynchronous and pass through a two-flop synchroniser.

Samples enter and leave on valid/ready streams with a single output register. A sample is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new sample is taken.

Top module: `chroma_mute_dropout`

## Requirements
- R1: With no strobe active, a sample accepted at a clock edge appears on `out_y`/`out_c` unchanged, with `out_valid` high, right after that edge.
- R2: When the delayed overlay strobe `blank_n` is low and `blank_ign` is 0, `out_c` is 128 and `out_y` is unaffected.
- R3: With `blank_ign` = 1, a low `blank_n` has no effect on `out_c`.
- R4: A high `vblank` mutes chroma to 128 when `vblank_ign` = 0. It has no effect when `vblank_ign` = 1.
- R5: A high `kill` mutes chroma to 128 whatever the values of `blank_ign` and `vblank_ign`.
- R6: While `doc_n` is low and `line_nr` = 1, `out_y` takes `dly_y` if `y_doc_en` = 1, and the chroma source is `dly_c` if `c_doc_en` = 1. Each path is controlled separately.
- R7: With `line_nr` = 0, a low `doc_n` causes no substitution on either path.
- R8: When a dropout and a mute fall on the same sample, chroma is 128 and luma still takes the delayed value.
- R9: With `blk_dly` = d (0 to 63), the overlay mute for a sample follows the synchronised `blank_n` level sampled at the acceptance of the sample d samples earlier.
- R10: A strobe change reaches the datapath only after two clock edges. A sample accepted at the first edge after a change still sees the old level.
- R11: `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_y` and `out_c` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank_n | input | 1 | Overlay blanking strobe, low mutes chroma (asynchronous) |
| vblank | input | 1 | Vertical blanking strobe, high mutes chroma (asynchronous) |
| kill | input | 1 | Monochrome strobe, high mutes chroma (asynchronous) |
| doc_n | input | 1 | Dropout strobe, low selects delayed samples (asynchronous) |
| blk_dly | input | 6 | Overlay mute delay in samples |
| blank_ign | input | 1 | 1: ignore `blank_n` |
| vblank_ign | input | 1 | 1: ignore `vblank` |
| line_nr | input | 1 | 1: line NR mode, dropout substitution allowed |
| y_doc_en | input | 1 | Enable dropout substitution on luma |
| c_doc_en | input | 1 | Enable dropout substitution on chroma |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| cur_y | input | 8 | Current luma sample |
| cur_c | input | 8 | Current chroma sample |
| dly_y | input | 8 | Delayed luma sample from memory |
| dly_c | input | 8 | Delayed chroma sample from memory |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_y | output | 8 | Selected luma |
| out_c | output | 8 | Selected, possibly muted, chroma |

## Verification
The two functions that can land on the same sample are dropout substitution and chroma muting, and they act on the same chroma path. The bench holds `doc_n` low with both enables set in line mode, raises `kill` before the same sample, and gives the current and delayed values distinct codes. The result is correct only if luma shows the delayed code and chroma shows exactly 128, not the delayed chroma. Back-pressure is the second overlap: a new sample is offered while the previous one stalls, and the bench checks that the held output does not move and that the waiting sample is taken in the cycle the stall releases.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int unsigned SAMPLE_W = 8;
  localparam int unsigned MAX_DLY  = 63;
  localparam int unsigned DLY_W    = $clog2(MAX_DLY + 1);

  function automatic logic [SAMPLE_W-1:0] mid_code();
    return {1'b1, {(SAMPLE_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= RST_VAL;
      sync_out <= RST_VAL;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/blank_delay.sv
module blank_delay #(
  parameter int unsigned DEPTH = 63,
  parameter int unsigned SEL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             level_now,
  input  logic [SEL_W-1:0] sel,
  output logic             level_out
);
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '1;
    else if (advance) hist <= {hist[DEPTH-2:0], level_now};
  end

  always_comb begin
    if (sel == '0) level_out = level_now;
    else           level_out = hist[sel - 1'b1];
  end
endmodule

// File: rtl/sample_select.sv
module sample_select #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] cur_y,
  input  logic [DW-1:0] cur_c,
  input  logic [DW-1:0] dly_y,
  input  logic [DW-1:0] dly_c,
  input  logic          drop,
  input  logic          line_nr,
  input  logic          y_doc_en,
  input  logic          c_doc_en,
  input  logic          mute,
  input  logic [DW-1:0] mute_code,
  output logic [DW-1:0] sel_y,
  output logic [DW-1:0] sel_c
);
  logic sub_ok;
  logic [DW-1:0] c_src;

  always_comb begin
    sub_ok = drop && line_nr;
    sel_y  = (sub_ok && y_doc_en) ? dly_y : cur_y;
    c_src  = (sub_ok && c_doc_en) ? dly_c : cur_c;
    sel_c  = mute ? mute_code : c_src;
  end
endmodule

// File: rtl/chroma_mute_dropout.sv
module chroma_mute_dropout
  import cmd_pkg::*;
#(
  parameter int unsigned DW      = SAMPLE_W,
  parameter int unsigned DLY_MAX = MAX_DLY,
  localparam int unsigned SW     = $clog2(DLY_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank_n,
  input  logic          vblank,
  input  logic          kill,
  input  logic          doc_n,
  input  logic [SW-1:0] blk_dly,
  input  logic          blank_ign,
  input  logic          vblank_ign,
  input  logic          line_nr,
  input  logic          y_doc_en,
  input  logic          c_doc_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] cur_y,
  input  logic [DW-1:0] cur_c,
  input  logic [DW-1:0] dly_y,
  input  logic [DW-1:0] dly_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [3:0] strobe_s;
  logic blank_n_s, vblank_s, kill_s, doc_n_s;
  logic blank_n_d, mute, acc;
  logic [DW-1:0] sel_y, sel_c;

  strobe_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({blank_n, vblank, kill, doc_n}),
    .sync_out(strobe_s)
  );
  assign {blank_n_s, vblank_s, kill_s, doc_n_s} = strobe_s;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  blank_delay #(.DEPTH(DLY_MAX), .SEL_W(SW)) u_dly (
    .clk(clk), .rst_n(rst_n), .advance(acc),
    .level_now(blank_n_s), .sel(blk_dly), .level_out(blank_n_d)
  );

  assign mute = kill_s || (!blank_n_d && !blank_ign) || (vblank_s && !vblank_ign);

  sample_select #(.DW(DW)) u_sel (
    .cur_y(cur_y), .cur_c(cur_c), .dly_y(dly_y), .dly_c(dly_c),
    .drop(!doc_n_s), .line_nr(line_nr), .y_doc_en(y_doc_en), .c_doc_en(c_doc_en),
    .mute(mute), .mute_code(MID), .sel_y(sel_y), .sel_c(sel_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= MID;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_y     <= sel_y;
      out_c     <= sel_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chroma_mute_dropout_chk.sv
module chroma_mute_dropout_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_c,
  input logic [DW-1:0] cur_y,
  input logic          line_nr,
  input logic          kill_s
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_c));

  a_r11_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r5_kill_mute: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && kill_s |=> out_c == MID);

  a_r7_no_subst: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !line_nr |=> out_y == $past(cur_y));
endmodule

bind chroma_mute_dropout chroma_mute_dropout_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y), .out_c(out_c),
  .cur_y(cur_y), .line_nr(line_nr), .kill_s(kill_s)
);

// File: tb/sim_chroma_mute_dropout.sv
`timescale 1ns/1ps
module sim_chroma_mute_dropout;
  logic clk = 0, rst_n = 0;
  logic blank_n = 1, vblank = 0, kill = 0, doc_n = 1;
  logic [5:0] blk_dly = 0;
  logic blank_ign = 0, vblank_ign = 0, line_nr = 0, y_doc_en = 0, c_doc_en = 0;
  logic in_valid = 0, out_ready = 1;
  logic [7:0] cur_y = 0, cur_c = 0, dly_y = 0, dly_c = 0;
  logic in_ready, out_valid;
  logic [7:0] out_y, out_c;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chroma_mute_dropout u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] y, c, dy, dc);
    @(negedge clk);
    cur_y = y; cur_c = c; dly_y = dy; dly_c = dc; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    check("R11 reset out_valid", out_valid, 0);
    check("R11 reset in_ready", in_ready, 1);
  endtask

  task automatic t_pass();
    send(8'h21, 8'h43, 8'h99, 8'h88);
    check("R1 valid", out_valid, 1);
    check("R1 y", out_y, 8'h21);
    check("R1 c", out_c, 8'h43);
    send(8'hF0, 8'h05, 8'h11, 8'h22);
    check("R1 c second", out_c, 8'h05);
  endtask

  task automatic t_blank();
    blank_n = 0; settle();
    send(8'h30, 8'h50, 0, 0);
    check("R2 c muted", out_c, 128);
    check("R2 y kept", out_y, 8'h30);
    blank_ign = 1; settle();
    send(8'h31, 8'h51, 0, 0);
    check("R3 blank ignored", out_c, 8'h51);
    blank_ign = 0; blank_n = 1; settle();
  endtask

  task automatic t_vblank();
    vblank = 1; settle();
    send(8'h32, 8'h52, 0, 0);
    check("R4 vblank mute", out_c, 128);
    vblank_ign = 1; settle();
    send(8'h33, 8'h53, 0, 0);
    check("R4 vblank ignored", out_c, 8'h53);
    vblank = 0; vblank_ign = 0; settle();
  endtask

  task automatic t_kill();
    blank_ign = 1; vblank_ign = 1; kill = 1; settle();
    send(8'h34, 8'h54, 0, 0);
    check("R5 kill mute", out_c, 128);
    kill = 0; blank_ign = 0; vblank_ign = 0; settle();
  endtask

  task automatic t_dropout();
    line_nr = 1; y_doc_en = 1; c_doc_en = 0; doc_n = 0; settle();
    send(8'h10, 8'h20, 8'hA0, 8'hB0);
    check("R6 y subst", out_y, 8'hA0);
    check("R6 c not subst", out_c, 8'h20);
    y_doc_en = 0; c_doc_en = 1;
    send(8'h11, 8'h21, 8'hA1, 8'hB1);
    check("R6 y not subst", out_y, 8'h11);
    check("R6 c subst", out_c, 8'hB1);
    line_nr = 0; y_doc_en = 1;
    send(8'h12, 8'h22, 8'hA2, 8'hB2);
    check("R7 y inhibited", out_y, 8'h12);
    check("R7 c inhibited", out_c, 8'h22);
    line_nr = 1; kill = 1; settle();
    send(8'h13, 8'h23, 8'hA3, 8'hB3);
    check("R8 y subst under mute", out_y, 8'hA3);
    check("R8 c muted", out_c, 128);
    kill = 0; doc_n = 1; line_nr = 0; y_doc_en = 0; c_doc_en = 0; settle();
  endtask

  task automatic t_delay();
    blk_dly = 3;
    for (int i = 0; i < 10; i++) begin
      blank_n = (i == 5) ? 1'b0 : 1'b1; settle();
      send(8'(i), 8'(60 + i), 0, 0);
      if (i >= 3) check("R9 delayed mute", out_c, (i == 8) ? 128 : 60 + i);
    end
    blk_dly = 0; blank_n = 1; settle();
  endtask

  task automatic t_sync();
    @(negedge clk);
    kill = 1; cur_y = 8'h44; cur_c = 8'h66; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 old level seen", out_c, 8'h66);
    settle();
    send(8'h45, 8'h67, 0, 0);
    check("R10 new level seen", out_c, 128);
    kill = 0; settle();
  endtask

  task automatic t_stall();
    out_ready = 0;
    send(8'h70, 8'h71, 0, 0);
    @(negedge clk);
    cur_y = 8'h72; cur_c = 8'h73; in_valid = 1;
    #1 check("R11 not ready", in_ready, 0);
    @(negedge clk);
    check("R11 held y", out_y, 8'h70);
    check("R11 held valid", out_valid, 1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R11 next taken", out_y, 8'h72);
    @(negedge clk);
    check("R11 drained", out_valid, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_blank();
    t_vblank();
    t_kill();
    t_dropout();
    t_delay();
    t_sync();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule